// File: doc/BRIEF.md
# Dual-Queue Instruction Pre-Decoder

This block sits between a byte-wide instruction buffer and two execution pipelines that run side by side. One pipeline handles floating-point work and the other handles integer work. Opcode bytes are written into an internal eight-entry instruction queue. Each cycle the block looks at the two oldest entries. It sorts each entry by its top bit and forwards at most one floating-point and one integer opcode into two separate eight-entry output queues. Each output queue drains on its own through a valid/ready port.

When the two oldest entries are of different kinds and both destinations have room, both leave in the same cycle. When they are of the same kind, only the older one leaves, so each output queue keeps program order. When the destination of the oldest entry is full, nothing leaves. The oldest entry waits at the head, and the entries behind it wait as well.

Top module: `insn_predecoder`

## Requirements
- R1: An opcode whose bit 7 is 1 is delivered only on the floating-point output (`fp_op`). An opcode whose bit 7 is 0 is delivered only on the integer output (`int_op`).
- R2: Each output delivers its opcodes in the order in which they were accepted at the input.
- R3: When the two oldest queued opcodes are of different kinds and neither destination queue is full, both are forwarded in the same cycle.
- R4: When the two oldest queued opcodes are of the same kind, only the older one is forwarded in that cycle.
- R5: Nothing is forwarded while the destination of the oldest queued opcode is full. That opcode stays at the head, and younger opcodes of the other kind stay behind it.
- R6: The instruction queue holds 8 opcodes. `in_ready` is 0 while it is full, and a write offered while `in_ready` is 0 is dropped.
- R7: Each output queue holds 8 opcodes, and `*_valid` is 1 exactly when its queue is not empty. While `*_valid` is 1 and `*_ready` is 0, the output holds the same opcode.
- R8: When all queues are empty, an opcode accepted at clock edge k appears on its output after clock edge k+1.
- R9: After reset all queues are empty: `in_ready` is 1, and `fp_valid` and `int_valid` are 0.
- R10: Every accepted opcode is delivered exactly once. No opcode is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write request into the instruction queue |
| in_op | input | 8 | Opcode byte to write |
| in_ready | output | 1 | Instruction queue can take a byte |
| fp_valid | output | 1 | Floating-point output queue not empty |
| fp_op | output | 8 | Oldest floating-point opcode |
| fp_ready | input | 1 | Floating-point consumer takes `fp_op` |
| int_valid | output | 1 | Integer output queue not empty |
| int_op | output | 8 | Oldest integer opcode |
| int_ready | input | 1 | Integer consumer takes `int_op` |

## Verification
The hardest case to reach from the ports is a head-of-line stall. In that case a full floating-point queue blocks two queued floating-point opcodes, and an integer opcode sits behind them. Opening a single slot must then release only the older floating-point opcode, and the integer opcode must stay behind the second one. The bench reaches this case directly. It holds `fp_ready` low until the floating-point queue is full, writes a floating-point, floating-point, integer triple, and then pulses `fp_ready` one cycle at a time. It checks `int_valid` after each pulse. Random phases that starve one consumer or the other then drive both queues into full and near-full states while an order scoreboard runs.

// File: rtl/predec_pkg.sv
package predec_pkg;

    localparam int OP_W      = 8;
    localparam int NUM_LANES = 2;
    localparam int LANE_INT  = 0;
    localparam int LANE_FP   = 1;

    typedef logic [OP_W-1:0] opcode_t;

    // one peeked entry of the instruction queue
    typedef struct packed {
        logic    valid;
        opcode_t op;
    } slot_t;

    // per-cycle routing decision
    typedef struct packed {
        logic [1:0]                      pop_n;
        logic [NUM_LANES-1:0]            push;
        logic [NUM_LANES-1:0][OP_W-1:0]  data;
    } dispatch_t;

    // destination lane from the opcode's top bit
    function automatic logic lane_of(opcode_t op);
        return op[OP_W-1];
    endfunction

endpackage

// File: rtl/iq_buffer.sv
module iq_buffer
    import predec_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  opcode_t    wr_data,
    input  logic [1:0] pop_n,
    output slot_t      head0,
    output slot_t      head1,
    output logic       full,
    output logic       empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    opcode_t              mem [DEPTH];
    logic [IDX_W-1:0]     rd_ptr;
    logic [IDX_W-1:0]     wr_ptr;
    logic [CNT_W-1:0]     count;

    function automatic logic [IDX_W-1:0] wrap_add(logic [IDX_W-1:0] p, logic [1:0] amt);
        logic [IDX_W:0] s;
        s = {1'b0, p} + (IDX_W+1)'(amt);
        if (s >= (IDX_W+1)'(DEPTH))
            s = s - (IDX_W+1)'(DEPTH);
        return s[IDX_W-1:0];
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    always_comb begin
        head0.valid = (count != '0);
        head0.op    = mem[rd_ptr];
        head1.valid = (count >= CNT_W'(2));
        head1.op    = mem[wrap_add(rd_ptr, 2'd1)];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en)
                wr_ptr <= wrap_add(wr_ptr, 2'd1);
            rd_ptr <= wrap_add(rd_ptr, pop_n);
            count  <= count + CNT_W'(wr_en) - CNT_W'(pop_n);
        end
    end

endmodule

// File: rtl/out_queue.sv
module out_queue
    import predec_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  opcode_t push_data,
    input  logic    ready,
    output logic    valid,
    output opcode_t data,
    output logic    full
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    opcode_t           mem [DEPTH];
    logic [IDX_W-1:0]  rd_ptr;
    logic [IDX_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop;

    function automatic logic [IDX_W-1:0] next_idx(logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid = (count != '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign data  = mem[rd_ptr];
    assign pop   = valid && ready;

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= next_idx(wr_ptr);
            if (pop)
                rd_ptr <= next_idx(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/pair_select.sv
module pair_select
    import predec_pkg::*;
(
    input  slot_t                  head0,
    input  slot_t                  head1,
    input  logic [NUM_LANES-1:0]   lane_full,
    output dispatch_t              disp
);
    logic lane0, lane1;
    logic take0, take1;

    always_comb begin
        lane0 = lane_of(head0.op);
        lane1 = lane_of(head1.op);
        // oldest entry leaves only when its lane has room
        take0 = head0.valid && !lane_full[lane0];
        // second entry pairs up only with an entry of the other kind
        take1 = take0 && head1.valid && (lane1 != lane0) && !lane_full[lane1];

        disp.pop_n = {1'b0, take0} + {1'b0, take1};
        for (int l = 0; l < NUM_LANES; l++) begin
            disp.push[l] = (take0 && (int'(lane0) == l)) || (take1 && (int'(lane1) == l));
            disp.data[l] = (take0 && (int'(lane0) == l)) ? head0.op : head1.op;
        end
    end

endmodule

// File: rtl/insn_predecoder.sv
module insn_predecoder
    import predec_pkg::*;
#(
    parameter int IQ_DEPTH  = 8,
    parameter int OUT_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    output logic            in_ready,
    output logic            fp_valid,
    output logic [OP_W-1:0] fp_op,
    input  logic            fp_ready,
    output logic            int_valid,
    output logic [OP_W-1:0] int_op,
    input  logic            int_ready
);
    slot_t                 head0, head1;
    logic                  iq_full, iq_empty;
    dispatch_t             disp;
    logic [1:0]            iq_pop_n;
    logic [NUM_LANES-1:0]  lane_full;
    logic [NUM_LANES-1:0]  lane_valid;
    logic [NUM_LANES-1:0]  lane_ready;
    opcode_t               lane_out [NUM_LANES];
    logic                  fp_push, int_push, fp_full, int_full;

    assign in_ready = !iq_full;
    assign iq_pop_n = disp.pop_n;

    iq_buffer #(.DEPTH(IQ_DEPTH)) u_iq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid && !iq_full),
        .wr_data (in_op),
        .pop_n   (iq_pop_n),
        .head0   (head0),
        .head1   (head1),
        .full    (iq_full),
        .empty   (iq_empty)
    );

    pair_select u_sel (
        .head0     (head0),
        .head1     (head1),
        .lane_full (lane_full),
        .disp      (disp)
    );

    assign lane_ready[LANE_FP]  = fp_ready;
    assign lane_ready[LANE_INT] = int_ready;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        out_queue #(.DEPTH(OUT_DEPTH)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (disp.push[g]),
            .push_data (disp.data[g]),
            .ready     (lane_ready[g]),
            .valid     (lane_valid[g]),
            .data      (lane_out[g]),
            .full      (lane_full[g])
        );
    end

    assign fp_valid  = lane_valid[LANE_FP];
    assign fp_op     = lane_out[LANE_FP];
    assign int_valid = lane_valid[LANE_INT];
    assign int_op    = lane_out[LANE_INT];
    assign fp_push   = disp.push[LANE_FP];
    assign int_push  = disp.push[LANE_INT];
    assign fp_full   = lane_full[LANE_FP];
    assign int_full  = lane_full[LANE_INT];

endmodule

// File: rtl/predec_checks.sv
module predec_checks
    import predec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_ready,
    input logic            fp_valid,
    input logic [OP_W-1:0] fp_op,
    input logic            fp_ready,
    input logic            int_valid,
    input logic [OP_W-1:0] int_op,
    input logic            int_ready,
    input logic            fp_push,
    input logic            int_push,
    input logic            fp_full,
    input logic            int_full,
    input logic            iq_full,
    input logic            iq_empty,
    input logic [1:0]      iq_pop_n
);
    assert_fp_class_R1: assert property (@(posedge clk) disable iff (rst)
        fp_valid |-> fp_op[OP_W-1]);

    assert_int_class_R1: assert property (@(posedge clk) disable iff (rst)
        int_valid |-> !int_op[OP_W-1]);

    assert_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (iq_pop_n == 2'd2) |-> (fp_push && int_push));

    assert_one_per_pop_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({fp_push, int_push}) == int'(iq_pop_n));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        !(fp_push && fp_full) && !(int_push && int_full));

    assert_empty_idle_R5: assert property (@(posedge clk) disable iff (rst)
        iq_empty |-> (iq_pop_n == 2'd0));

    assert_refuse_R6: assert property (@(posedge clk) disable iff (rst)
        (iq_full && iq_pop_n == 2'd0) |=> (iq_full && !in_ready));

    assert_fp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (fp_valid && !fp_ready) |=> (fp_valid && $stable(fp_op)));

    assert_int_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (int_valid && !int_ready) |=> (int_valid && $stable(int_op)));

endmodule

bind insn_predecoder predec_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .fp_valid  (fp_valid),
    .fp_op     (fp_op),
    .fp_ready  (fp_ready),
    .int_valid (int_valid),
    .int_op    (int_op),
    .int_ready (int_ready),
    .fp_push   (fp_push),
    .int_push  (int_push),
    .fp_full   (fp_full),
    .int_full  (int_full),
    .iq_full   (iq_full),
    .iq_empty  (iq_empty),
    .iq_pop_n  (iq_pop_n)
);

// File: tb/insn_predecoder_test.sv
module insn_predecoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_op;
    logic       in_ready;
    logic       fp_valid, int_valid;
    logic [7:0] fp_op, int_op;
    logic       fp_ready, int_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_predecoder uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_op(in_op), .in_ready(in_ready),
        .fp_valid(fp_valid), .fp_op(fp_op), .fp_ready(fp_ready),
        .int_valid(int_valid), .int_op(int_op), .int_ready(int_ready)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] exp_fp[$];
    logic [7:0] exp_int[$];
    bit         hold_fp  = 0, hold_int = 0;
    logic [7:0] hold_fp_op, hold_int_op;

    // R1: bit 7 selects the floating-point lane
    function automatic bit is_fp(logic [7:0] b);
        return b[7];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one cycle: called at a falling edge, returns at the next falling edge
    task automatic step(bit v, logic [7:0] op, bit fr, bit ir);
        logic [7:0] e;
        in_valid  = v;
        in_op     = op;
        fp_ready  = fr;
        int_ready = ir;
        if (hold_fp)
            check(fp_valid && fp_op == hold_fp_op, "R7", "fp output held", int'(fp_op), int'(hold_fp_op));
        if (hold_int)
            check(int_valid && int_op == hold_int_op, "R7", "int output held", int'(int_op), int'(hold_int_op));
        if (v && in_ready) begin
            if (is_fp(op)) exp_fp.push_back(op);
            else           exp_int.push_back(op);
        end
        if (fr && fp_valid) begin
            check(fp_op[7], "R1", "fp lane opcode class", int'(fp_op[7]), 1);
            if (exp_fp.size() == 0)
                check(0, "R10", "unexpected fp opcode", int'(fp_op), 0);
            else begin
                e = exp_fp.pop_front();
                check(fp_op == e, "R2", "fp order", int'(fp_op), int'(e));
            end
        end
        if (ir && int_valid) begin
            check(!int_op[7], "R1", "int lane opcode class", int'(int_op[7]), 0);
            if (exp_int.size() == 0)
                check(0, "R10", "unexpected int opcode", int'(int_op), 0);
            else begin
                e = exp_int.pop_front();
                check(int_op == e, "R2", "int order", int'(int_op), int'(e));
            end
        end
        hold_fp     = fp_valid && !fr;
        hold_fp_op  = fp_op;
        hold_int    = int_valid && !ir;
        hold_int_op = int_op;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n, bit fr, bit ir);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, fr, ir);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int acc;
        int pct_fp, pct_int;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; in_valid = 0; in_op = 0; fp_ready = 0; int_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        check(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
        check(fp_valid == 1'b0, "R9", "fp_valid after reset", int'(fp_valid), 0);
        check(int_valid == 1'b0, "R9", "int_valid after reset", int'(int_valid), 0);

        // R8: latency through empty queues
        step(1'b1, 8'h15, 1'b0, 1'b0);
        check(int_valid == 1'b0, "R8", "int_valid one edge after write", int'(int_valid), 0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check(int_valid == 1'b1 && int_op == 8'h15, "R8", "int_op two edges after write", int'(int_op), 'h15);
        check(fp_valid == 1'b0, "R1", "integer opcode kept off fp lane", int'(fp_valid), 0);
        idle(4, 1'b1, 1'b1);

        // R6: capacity and refused writes (fp lane blocked)
        acc = 0;
        for (int i = 0; i < 20; i++) begin
            if (in_ready) acc++;
            step(1'b1, 8'h80 | 8'(i), 1'b0, 1'b0);
        end
        check(acc == 16, "R6", "bytes accepted with fp lane blocked", acc, 16);
        check(in_ready == 1'b0, "R6", "in_ready when instruction queue full", int'(in_ready), 0);
        check(fp_valid && fp_op == 8'h80, "R7", "fp head while blocked", int'(fp_op), 'h80);
        idle(40, 1'b1, 1'b1);
        check(exp_fp.size() == 0, "R6", "refused bytes not delivered, accepted all drained", exp_fp.size(), 0);

        // R3/R4/R5: head-of-line stall on full fp lane
        for (int i = 0; i < 8; i++) step(1'b1, 8'hC0 + 8'(i), 1'b0, 1'b0);
        step(1'b1, 8'hA1, 1'b0, 1'b0);
        step(1'b1, 8'hB2, 1'b0, 1'b0);
        step(1'b1, 8'h33, 1'b0, 1'b0);
        idle(4, 1'b0, 1'b0);
        check(int_valid == 1'b0, "R5", "int opcode held behind blocked fp head", int'(int_valid), 0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check(int_valid == 1'b0, "R4", "same-kind pair releases one only", int'(int_valid), 0);
        idle(3, 1'b0, 1'b0);
        check(int_valid == 1'b0, "R4", "int still behind second fp", int'(int_valid), 0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check(int_valid == 1'b1 && int_op == 8'h33, "R3", "mixed pair forwarded together", int'(int_op), 'h33);
        idle(30, 1'b1, 1'b1);

        // random phases with varying consumer pressure
        for (int c = 0; c < 4000; c++) begin
            case ((c / 500) % 4)
                0: begin pct_fp = 90; pct_int = 90; end
                1: begin pct_fp = 10; pct_int = 70; end
                2: begin pct_fp = 70; pct_int = 5;  end
                default: begin pct_fp = 40; pct_int = 40; end
            endcase
            step(($urandom % 100) < 75, 8'($urandom),
                 ($urandom % 100) < pct_fp, ($urandom % 100) < pct_int);
        end
        idle(60, 1'b1, 1'b1);

        // R10: everything delivered exactly once
        check(exp_fp.size() == 0, "R10", "fp opcodes outstanding", exp_fp.size(), 0);
        check(exp_int.size() == 0, "R10", "int opcodes outstanding", exp_int.size(), 0);
        check(!fp_valid && !int_valid, "R7", "valids low when queues empty",
              int'({fp_valid, int_valid}), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule